// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This block decides when a small processor core may run. A one-shot reset-delay timer holds the core in reset after power comes up, after a watchdog timeout, or after a wake from the deepest sleep state, so that the supply and oscillator can settle first. The timer counts pulses of a slow, dedicated on-chip RC clock. Those pulses reach the block as a single-cycle `slow_tick` strobe that is already synchronised to `clk`. When the count expires, the core reset is released on a `clk` edge.

The block also runs two sleep states. Both are entered only when the pipeline is reported empty. In light sleep, the CPU clock is gated but the main oscillator and peripheral clocks keep running, and any pending interrupt wakes the core. In deep sleep, the CPU clock, the peripheral clock and the main oscillator are all off, and only a reset source ends it. A stop-recovery event can either run the full delay or release the core after a single reset cycle, depending on a configuration bit. Every reset release presents a fixed restart vector to the core.

Top module: `pms_seq`

## Requirements
- R1: After `rst_n` is released with `pwr_ok` low, the outputs are `core_rst`=1, `cpu_clk_en`=0, `periph_clk_en`=0, `osc_en`=1.
- R2: A rising edge of `pwr_ok` starts the delay. `core_rst` then stays 1 until exactly DELAY_TICKS `slow_tick` pulses have been consumed, and falls in the cycle after the last one.
- R3: `pwr_ok` low in any state makes `core_rst`=1 and `cpu_clk_en`=0 in the next cycle.
- R4: `wdt_timeout` high in any state, including a sleep state, starts the delay, so `core_rst`=1 in the next cycle.
- R5: A trigger that arrives while the delay is running restarts the count from zero.
- R6: Light sleep is entered when `halt_req`=1 and `pipe_empty`=1. It gives `cpu_clk_en`=0, `osc_en`=1, `periph_clk_en`=1. A request made without `pipe_empty` is ignored.
- R7: In light sleep, `irq_pending`=1 restores `cpu_clk_en`=1 in the next cycle, and `core_rst` stays 0.
- R8: Deep sleep is entered when `stop_req`=1 and `pipe_empty`=1, and it takes priority over `halt_req`. It gives `osc_en`=0, `cpu_clk_en`=0, `periph_clk_en`=0.
- R9: In deep sleep, `irq_pending` has no effect.
- R10: In deep sleep, a `stop_recov` pulse has one of two effects. With `smr_delay_en`=1 it runs the full delay of R2. With `smr_delay_en`=0 it gives exactly one cycle of `core_rst`=1 and then running.
- R11: `ext_rst_n` low while running or sleeping holds `core_rst`=1. The core runs again in the cycle after the pin returns high. While the delay runs, the pin is ignored.
- R12: `restart_vec` equals RESTART_VEC (default 0x000C) whenever `core_rst`=1, and 0 otherwise.
- R13: Without `slow_tick` pulses the delay does not advance, however many `clk` cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CPU domain) |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| slow_tick | input | 1 | One-cycle strobe per RC-clock period, synchronised to clk |
| pwr_ok | input | 1 | Supply status, 1 = good |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| stop_recov | input | 1 | Deep-sleep recovery event |
| smr_delay_en | input | 1 | 1 = run the delay after stop recovery, 0 = bypass it |
| halt_req | input | 1 | Light-sleep request |
| stop_req | input | 1 | Deep-sleep request |
| pipe_empty | input | 1 | Instruction boundary reached, pipeline flushed |
| irq_pending | input | 1 | Any enabled interrupt pending |
| core_rst | output | 1 | Core reset, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Counter/timer clock enable |
| restart_vec | output | VEC_W | Restart address presented during core reset |

## Verification
The bench builds the block with DELAY_TICKS=6 instead of the 5000-tick default, with VEC_W and RESTART_VEC left at their defaults. The short delay puts the exact release cycle, restarts in the middle of a count and count-exhaustion boundaries within a few dozen cycles. The bench counts the `slow_tick` pulses it delivers, spaced either every cycle or every third cycle, so each delay check compares a pulse count rather than a cycle count.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [2:0] {
        ST_PWRDN = 3'd0,
        ST_DELAY = 3'd1,
        ST_SHORT = 3'd2,
        ST_RUN   = 3'd3,
        ST_HALT  = 3'd4,
        ST_STOP  = 3'd5
    } pms_state_e;

    typedef struct packed {
        pms_state_e state;
    } pms_seq_t;
endpackage

// File: rtl/pms_rise.sv
module pms_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pms_dly_ctr.sv
module pms_dly_ctr #(
    parameter int TICKS = 5000,
    localparam int CW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          at_last
);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clr)                  cnt_d = '0;
        else if (step && !at_last) cnt_d = cnt_q + 1'b1;
        cnt = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pms_out_dec.sv
module pms_out_dec
    import pms_pkg::*;
#(
    parameter int              VEC_W       = 16,
    parameter logic [VEC_W-1:0] RESTART_VEC = 16'h000C
) (
    input  pms_state_e       state,
    output logic             core_rst,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic [VEC_W-1:0] restart_vec
);
    always_comb begin
        core_rst      = (state == ST_PWRDN) || (state == ST_DELAY) || (state == ST_SHORT);
        cpu_clk_en    = (state == ST_RUN);
        periph_clk_en = (state == ST_RUN) || (state == ST_HALT);
        osc_en        = (state != ST_STOP);
        restart_vec   = core_rst ? RESTART_VEC : '0;
    end
endmodule

// File: rtl/pms_seq.sv
module pms_seq
    import pms_pkg::*;
#(
    parameter int               DELAY_TICKS = 5000,
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] RESTART_VEC = 16'h000C,
    localparam int              CW          = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             pwr_ok,
    input  logic             ext_rst_n,
    input  logic             wdt_timeout,
    input  logic             stop_recov,
    input  logic             smr_delay_en,
    input  logic             halt_req,
    input  logic             stop_req,
    input  logic             pipe_empty,
    input  logic             irq_pending,
    output logic             core_rst,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic [VEC_W-1:0] restart_vec
);
    pms_seq_t      seq_d, seq_q;
    logic          pwr_rise;
    logic          dly_clr;
    logic          dly_step;
    logic          dly_last;
    logic [CW-1:0] dly_cnt;

    pms_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwr_ok),
        .rise  (pwr_rise)
    );

    pms_dly_ctr #(.TICKS(DELAY_TICKS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dly_clr),
        .step    (dly_step),
        .cnt     (dly_cnt),
        .at_last (dly_last)
    );

    always_comb begin
        seq_d   = seq_q;
        dly_clr = 1'b0;
        if (!pwr_ok) begin
            seq_d.state = ST_PWRDN;
        end else if (pwr_rise || wdt_timeout) begin
            seq_d.state = ST_DELAY;
            dly_clr     = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_PWRDN: begin
                    seq_d.state = ST_DELAY;
                    dly_clr     = 1'b1;
                end
                ST_DELAY: begin
                    if (slow_tick && dly_last) seq_d.state = ST_RUN;
                end
                ST_SHORT: begin
                    if (ext_rst_n) seq_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (!ext_rst_n)                  seq_d.state = ST_SHORT;
                    else if (pipe_empty && stop_req) seq_d.state = ST_STOP;
                    else if (pipe_empty && halt_req) seq_d.state = ST_HALT;
                end
                ST_HALT: begin
                    if (!ext_rst_n)       seq_d.state = ST_SHORT;
                    else if (irq_pending) seq_d.state = ST_RUN;
                end
                ST_STOP: begin
                    if (!ext_rst_n) begin
                        seq_d.state = ST_SHORT;
                    end else if (stop_recov) begin
                        if (smr_delay_en) begin
                            seq_d.state = ST_DELAY;
                            dly_clr     = 1'b1;
                        end else begin
                            seq_d.state = ST_SHORT;
                        end
                    end
                end
                default: seq_d.state = ST_PWRDN;
            endcase
        end
        dly_step = (seq_q.state == ST_DELAY) && slow_tick && !dly_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_PWRDN};
        else        seq_q <= seq_d;
    end

    pms_out_dec #(.VEC_W(VEC_W), .RESTART_VEC(RESTART_VEC)) u_dec (
        .state         (seq_q.state),
        .core_rst      (core_rst),
        .cpu_clk_en    (cpu_clk_en),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .restart_vec   (restart_vec)
    );
endmodule

// File: rtl/pms_seq_chk.sv
module pms_seq_chk #(
    parameter int               DELAY_TICKS = 5000,
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] RESTART_VEC = 16'h000C,
    parameter int               CW          = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_ok,
    input logic             ext_rst_n,
    input logic             wdt_timeout,
    input logic             stop_recov,
    input logic             smr_delay_en,
    input logic             pipe_empty,
    input logic             irq_pending,
    input logic             core_rst,
    input logic             cpu_clk_en,
    input logic             osc_en,
    input logic             periph_clk_en,
    input logic [VEC_W-1:0] restart_vec,
    input logic [CW-1:0]    dly_cnt
);
    logic quiet;
    assign quiet = pwr_ok && ext_rst_n && !wdt_timeout;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dly_cnt <= CW'(DELAY_TICKS - 1));

    assert_pwr_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> core_rst && !cpu_clk_en);

    assert_wdt_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout && pwr_ok |=> core_rst);

    assert_no_early_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && !pipe_empty && quiet |=> cpu_clk_en);

    assert_halt_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clk_en && !cpu_clk_en && irq_pending && quiet |=> cpu_clk_en && !core_rst);

    assert_stop_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en && !periph_clk_en && !core_rst);

    assert_stop_deaf_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && irq_pending && !stop_recov && quiet |=> !osc_en);

    assert_bypass_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && stop_recov && !smr_delay_en && quiet |=> core_rst && osc_en);

    assert_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> restart_vec == RESTART_VEC);
endmodule

bind pms_seq pms_seq_chk #(
    .DELAY_TICKS (DELAY_TICKS),
    .VEC_W       (VEC_W),
    .RESTART_VEC (RESTART_VEC),
    .CW          (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_ok        (pwr_ok),
    .ext_rst_n     (ext_rst_n),
    .wdt_timeout   (wdt_timeout),
    .stop_recov    (stop_recov),
    .smr_delay_en  (smr_delay_en),
    .pipe_empty    (pipe_empty),
    .irq_pending   (irq_pending),
    .core_rst      (core_rst),
    .cpu_clk_en    (cpu_clk_en),
    .osc_en        (osc_en),
    .periph_clk_en (periph_clk_en),
    .restart_vec   (restart_vec),
    .dly_cnt       (dly_cnt)
);

// File: tb/tb_pms_seq.sv
module tb_pms_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int VW         = 16;
    localparam logic [VW-1:0] VEC = 16'h000C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0, pwr_ok = 1'b0, ext_rst_n = 1'b1, wdt_timeout = 1'b0;
    logic stop_recov = 1'b0, smr_delay_en = 1'b1, halt_req = 1'b0, stop_req = 1'b0;
    logic pipe_empty = 1'b0, irq_pending = 1'b0;
    logic core_rst, cpu_clk_en, osc_en, periph_clk_en;
    logic [VW-1:0] restart_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pms_seq #(.DELAY_TICKS(N), .VEC_W(VW), .RESTART_VEC(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pwr_ok(pwr_ok),
        .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout), .stop_recov(stop_recov),
        .smr_delay_en(smr_delay_en), .halt_req(halt_req), .stop_req(stop_req),
        .pipe_empty(pipe_empty), .irq_pending(irq_pending), .core_rst(core_rst),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
        .restart_vec(restart_vec)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts slow ticks consumed while core_rst is high; ticks every 'period' cycles
    task automatic wait_release(input int period, output int ticks);
        int cyc = 0;
        ticks = 0;
        while (core_rst && cyc < 500) begin
            slow_tick = ((cyc % period) == period - 1);
            if (slow_tick) ticks++;
            step();
            cyc++;
        end
        slow_tick = 1'b0;
    endtask

    task automatic wdt_pulse();
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
    endtask

    task automatic t_reset();
        step();
        chk("R1 core_rst", core_rst, 1);
        chk("R1 cpu_clk_en", cpu_clk_en, 0);
        chk("R1 periph_clk_en", periph_clk_en, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R12 vec in reset", restart_vec, VEC);
    endtask

    task automatic t_power_up();
        int t;
        pwr_ok = 1'b1;
        step();
        chk("R2 held after pwr rise", core_rst, 1);
        wait_release(1, t);
        chk("R2 ticks to release", t, N);
        chk("R2 cpu runs", cpu_clk_en, 1);
        chk("R12 vec zero when running", restart_vec, 0);
    endtask

    task automatic t_slow_tick();
        int t;
        wdt_pulse();
        repeat (12) step();
        chk("R13 no ticks no release", core_rst, 1);
        wait_release(3, t);
        chk("R13 sparse ticks count", t, N);
    endtask

    task automatic t_wdt_restart();
        int t;
        wdt_pulse();
        chk("R4 wdt resets", core_rst, 1);
        slow_tick = 1'b1;
        repeat (3) step();
        slow_tick = 1'b0;
        chk("R5 still held mid count", core_rst, 1);
        wdt_pulse();
        wait_release(1, t);
        chk("R5 full count after retrigger", t, N);
    endtask

    task automatic t_power_fail();
        int t;
        pwr_ok = 1'b0;
        step();
        chk("R3 core_rst on fail", core_rst, 1);
        chk("R3 cpu off on fail", cpu_clk_en, 0);
        chk("R12 vec on fail", restart_vec, VEC);
        repeat (3) step();
        pwr_ok = 1'b1;
        step();
        wait_release(1, t);
        chk("R2 ticks after repower", t, N);
    endtask

    task automatic t_halt();
        halt_req = 1'b1;
        step();
        chk("R6 no flush ignored", cpu_clk_en, 1);
        pipe_empty = 1'b1;
        step();
        halt_req = 1'b0; pipe_empty = 1'b0;
        chk("R6 cpu gated", cpu_clk_en, 0);
        chk("R6 osc on", osc_en, 1);
        chk("R6 periph on", periph_clk_en, 1);
        repeat (3) step();
        chk("R6 stays asleep", cpu_clk_en, 0);
        irq_pending = 1'b1;
        step();
        irq_pending = 1'b0;
        chk("R7 woke", cpu_clk_en, 1);
        chk("R7 no reset", core_rst, 0);
    endtask

    task automatic enter_stop();
        stop_req = 1'b1; halt_req = 1'b1; pipe_empty = 1'b1;
        step();
        stop_req = 1'b0; halt_req = 1'b0; pipe_empty = 1'b0;
    endtask

    task automatic t_stop();
        enter_stop();
        chk("R8 osc off", osc_en, 0);
        chk("R8 cpu off", cpu_clk_en, 0);
        chk("R8 periph off", periph_clk_en, 0);
        irq_pending = 1'b1;
        repeat (3) step();
        chk("R9 irq ignored osc", osc_en, 0);
        chk("R9 irq ignored cpu", cpu_clk_en, 0);
        irq_pending = 1'b0;
    endtask

    task automatic t_stop_recov();
        int t;
        smr_delay_en = 1'b0; stop_recov = 1'b1;
        step();
        stop_recov = 1'b0;
        chk("R10 bypass one reset cycle", core_rst, 1);
        chk("R12 vec on bypass", restart_vec, VEC);
        step();
        chk("R10 bypass released", core_rst, 0);
        chk("R10 bypass cpu on", cpu_clk_en, 1);
        enter_stop();
        smr_delay_en = 1'b1; stop_recov = 1'b1;
        step();
        stop_recov = 1'b0;
        chk("R10 delayed recovery held", core_rst, 1);
        wait_release(1, t);
        chk("R10 delayed recovery ticks", t, N);
    endtask

    task automatic t_ext_pin();
        int t;
        halt_req = 1'b1; pipe_empty = 1'b1;
        step();
        halt_req = 1'b0; pipe_empty = 1'b0;
        ext_rst_n = 1'b0;
        step();
        chk("R11 pin resets from halt", core_rst, 1);
        repeat (4) step();
        chk("R11 held while low", core_rst, 1);
        ext_rst_n = 1'b1;
        step();
        chk("R11 released", core_rst, 0);
        chk("R11 runs", cpu_clk_en, 1);
        wdt_pulse();
        ext_rst_n = 1'b0;
        wait_release(1, t);
        ext_rst_n = 1'b1;
        chk("R11 pin ignored in delay", t, N);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_power_up();
        t_slow_tick();
        t_wdt_restart();
        t_power_fail();
        t_halt();
        t_stop();
        t_stop_recov();
        t_ext_pin();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule